// File: doc/BRIEF.md
# Configuration Setup Sequencer

This block is the control state machine that takes a programmable device from power-on, or from a reprogram request, to the point where configuration data can be accepted, and then walks it through the later configuration stages to completion. It clears the configuration memory, which is modelled here as a counter of clear cycles. While it does so it pulls an open-drain init-status line low. It honours external holds that delay configuration, latches the mode pins when the init line rises, and runs the configuration clock only for the modes in which the device is the clock master.

Once the mode is latched, the sequencer advances through synchronization, device-ID check, data load, CRC check and startup. An external stage engine moves it on with a one-cycle ready pulse and can flag a failure with a one-cycle error pulse. Configuration data words are captured on rising edges of the configuration clock: one bit wide in serial modes and eight bits wide in parallel modes. The user I/O enable stays off until the finish stage.

Top module: `cfg_setup_seq`

## Requirements
- R1: Any of these starts memory clearing: power-on reset (`por_n` low), an accepted program request, or a one-cycle `jtag_prog` pulse. Clearing shows as stage code 1 with `init_pull` high, `done` low and `user_io_en` low.
- R2: `prog_n` must be sampled low on PROG_MIN consecutive clock edges to be accepted. A shorter low pulse has no effect on the stage. An accepted request enters clearing on the following edge.
- R3: For as long as `prog_n` stays low after acceptance, the stage stays at 1 and `init_pull` stays high, with clearing repeated. After release, the pass in progress completes and `init_pull` drops within CLEAR_CYCLES cycles.
- R4: After power-on reset is released, `init_pull` stays high for exactly CLEAR_CYCLES+1 clock cycles: one power-on cycle plus CLEAR_CYCLES clear cycles. It then drops and the stage becomes 2 (wait/sample mode).
- R5: While `init_in` is sensed low in stage 2, the sequencer waits there for any length of time.
- R6: `mode_q` takes the value of `mode_pins` on the edge where `init_in` is first sensed high in stage 2. Later changes on `mode_pins` have no effect on `mode_q`.
- R7: After the sequencer leaves stage 2, `init_in` going low does not delay or restart configuration.
- R8: Mode encoding: bit 1 = 1 means slave, bit 1 = 0 means master; bit 0 = 1 means parallel. In stages 3 to 7 with a master mode, `cfg_clk_oe` is high and `cfg_clk_out` toggles every CCLK_HALF cycles. In slave modes, `cfg_clk_oe` stays low and `cfg_clk_out` stays low.
- R9: On each rising configuration-clock edge in stages 3 to 7, `cfg_word` loads the data. In parallel modes it takes `cfg_din[7:0]`. In serial modes it takes `cfg_din[0]` zero-extended. In master modes the clock is the internal clock; in slave modes it is `cfg_clk_in`.
- R10: Stage codes run in the order 0 power-on, 1 clear, 2 wait/sample mode, 3 sync, 4 ID check, 5 load, 6 CRC check, 7 startup, 8 finish. Each `stage_rdy` pulse in stages 3 to 7 advances the stage by exactly one.
- R11: A `stage_err` pulse in stage 4 or stage 6 moves to stage 9 (error), which holds `init_pull` high until a reset source arrives. `stage_err` in any other stage has no effect.
- R12: `done` and `user_io_en` are high only in stage 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| por_n | input | 1 | power-on reset, active low |
| prog_n | input | 1 | program request, active low, debounced |
| jtag_prog | input | 1 | test-port reprogram request pulse |
| init_in | input | 1 | sensed level of the open-drain init line |
| init_pull | output | 1 | pulls the init line low when high |
| user_io_en | output | 1 | enables user I/O drivers |
| mode_pins | input | 2 | mode straps |
| mode_q | output | 2 | latched mode |
| cfg_clk_in | input | 1 | external configuration clock for slave modes |
| cfg_clk_out | output | 1 | configuration clock driven in master modes |
| cfg_clk_oe | output | 1 | output enable of cfg_clk_out |
| cfg_din | input | 8 | configuration data pins |
| cfg_word | output | 8 | last captured data word |
| cfg_word_vld | output | 1 | one-cycle pulse after each capture |
| stage_rdy | input | 1 | current stage finished |
| stage_err | input | 1 | ID mismatch or CRC error |
| stage | output | 4 | current stage code |
| done | output | 1 | configuration finished |

## Verification
The assertions assume that `stage_rdy`, `stage_err`, `jtag_prog` and the other inputs are synchronous to `clk`. They also assume that `init_in` reflects the wired-AND of `init_pull` and any external hold. The bench builds `init_in` from exactly that model and changes every input only at falling clock edges. It changes `cfg_din` only while the relevant configuration clock is low or stable, and it issues ready and error pulses one cycle wide, so a single pulse never advances more than one stage.

// File: rtl/cfg_setup_seq.sv
module cfg_setup_seq #(
  parameter int CLEAR_CYCLES = 16,
  parameter int PROG_MIN     = 4,
  parameter int CCLK_HALF    = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       prog_n,
  input  logic       jtag_prog,
  input  logic       init_in,
  output logic       init_pull,
  output logic       user_io_en,
  input  logic [1:0] mode_pins,
  output logic [1:0] mode_q,
  input  logic       cfg_clk_in,
  output logic       cfg_clk_out,
  output logic       cfg_clk_oe,
  input  logic [7:0] cfg_din,
  output logic [7:0] cfg_word,
  output logic       cfg_word_vld,
  input  logic       stage_rdy,
  input  logic       stage_err,
  output logic [3:0] stage,
  output logic       done
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam int PW = $clog2(PROG_MIN + 1);
  localparam int HW = $clog2(CCLK_HALF + 1);

  typedef enum logic [3:0] {
    ST_POR = 4'd0, ST_CLEAR = 4'd1, ST_WAIT = 4'd2, ST_SYNC = 4'd3,
    ST_ID = 4'd4, ST_LOAD = 4'd5, ST_CRC = 4'd6, ST_STARTUP = 4'd7,
    ST_DONE = 4'd8, ST_ERR = 4'd9
  } st_t;

  st_t           st;
  logic [CW-1:0] clr_cnt;
  logic [PW-1:0] prog_cnt;
  logic [HW-1:0] div_cnt;
  logic          cclk_q, sclk_s, sclk_p;
  logic          prog_hold, active, master, rise, clr_last;

  assign prog_hold  = (prog_cnt == PW'(PROG_MIN));
  assign clr_last   = (clr_cnt == CW'(CLEAR_CYCLES - 1));
  assign active     = (st inside {ST_SYNC, ST_ID, ST_LOAD, ST_CRC, ST_STARTUP});
  assign master     = ~mode_q[1];
  assign init_pull  = (st inside {ST_POR, ST_CLEAR, ST_ERR});
  assign user_io_en = (st == ST_DONE);
  assign done       = (st == ST_DONE);
  assign stage      = st;
  assign cfg_clk_oe = active & master;
  assign cfg_clk_out = cclk_q & cfg_clk_oe;
  assign rise = active & (master ? (div_cnt == HW'(CCLK_HALF - 1) && !cclk_q)
                                 : (sclk_s & ~sclk_p));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       prog_cnt <= '0;
    else if (prog_n)  prog_cnt <= '0;
    else if (!prog_hold) prog_cnt <= prog_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= ST_POR;
      clr_cnt <= '0;
      mode_q  <= '0;
    end else if (jtag_prog || (prog_hold && st != ST_CLEAR)) begin
      st      <= ST_CLEAR;
      clr_cnt <= '0;
    end else begin
      case (st)
        ST_POR: begin
          st      <= ST_CLEAR;
          clr_cnt <= '0;
        end
        ST_CLEAR: begin
          if (clr_last) begin
            clr_cnt <= '0;
            if (!prog_hold) st <= ST_WAIT;
          end else begin
            clr_cnt <= clr_cnt + 1'b1;
          end
        end
        ST_WAIT: if (init_in) begin
          mode_q <= mode_pins;
          st     <= ST_SYNC;
        end
        ST_SYNC:    if (stage_rdy) st <= ST_ID;
        ST_ID:      if (stage_err) st <= ST_ERR; else if (stage_rdy) st <= ST_LOAD;
        ST_LOAD:    if (stage_rdy) st <= ST_CRC;
        ST_CRC:     if (stage_err) st <= ST_ERR; else if (stage_rdy) st <= ST_STARTUP;
        ST_STARTUP: if (stage_rdy) st <= ST_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      div_cnt <= '0;
      cclk_q  <= 1'b0;
    end else if (!(active && master)) begin
      div_cnt <= '0;
      cclk_q  <= 1'b0;
    end else if (div_cnt == HW'(CCLK_HALF - 1)) begin
      div_cnt <= '0;
      cclk_q  <= ~cclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sclk_s       <= 1'b0;
      sclk_p       <= 1'b0;
      cfg_word     <= '0;
      cfg_word_vld <= 1'b0;
    end else begin
      sclk_s       <= cfg_clk_in;
      sclk_p       <= sclk_s;
      cfg_word_vld <= rise;
      if (rise) cfg_word <= mode_q[0] ? cfg_din : {7'd0, cfg_din[0]};
    end
  end

  assert_prog_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    prog_hold |=> st == ST_CLEAR);

  assert_jtag_restart_R1: assert property (@(posedge clk) disable iff (!por_n)
    jtag_prog |=> (st == ST_CLEAR && clr_cnt == '0));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (active || st == ST_DONE || st == ST_ERR) |=> $stable(mode_q));

  assert_stage_order_R10: assert property (@(posedge clk) disable iff (!por_n)
    (active && !jtag_prog && !prog_hold) |=>
      (stage == $past(stage) || stage == $past(stage) + 4'd1 || stage == 4'd9));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!por_n)
    $rose(st == ST_ERR) |-> $past(stage_err));

  assert_clk_master_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cfg_clk_out) |-> !mode_q[1]);

  assert_done_entry_R12: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> $past(stage) == 4'd7);

  assert_clear_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_CLEAR) |-> init_pull && !user_io_en && clr_cnt < CW'(CLEAR_CYCLES));
endmodule

// File: tb/test_cfg_setup_seq.sv
module test_cfg_setup_seq;
  localparam int CLR = 16, PMIN = 4, HALF = 2;

  logic clk = 0, por_n = 0, prog_n = 1, jtag_prog = 0, ext_hold = 0;
  logic init_pull, user_io_en, cfg_clk_in = 0, cfg_clk_out, cfg_clk_oe, cfg_word_vld;
  logic stage_rdy = 0, stage_err = 0, done, init_in;
  logic [1:0] mode_pins = 0, mode_q;
  logic [7:0] cfg_din = 0, cfg_word;
  logic [3:0] stage;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign init_in = ~(init_pull | ext_hold);

  cfg_setup_seq #(.CLEAR_CYCLES(CLR), .PROG_MIN(PMIN), .CCLK_HALF(HALF)) i_cfg_setup_seq (
    .clk(clk), .por_n(por_n), .prog_n(prog_n), .jtag_prog(jtag_prog), .init_in(init_in),
    .init_pull(init_pull), .user_io_en(user_io_en), .mode_pins(mode_pins), .mode_q(mode_q),
    .cfg_clk_in(cfg_clk_in), .cfg_clk_out(cfg_clk_out), .cfg_clk_oe(cfg_clk_oe),
    .cfg_din(cfg_din), .cfg_word(cfg_word), .cfg_word_vld(cfg_word_vld),
    .stage_rdy(stage_rdy), .stage_err(stage_err), .stage(stage), .done(done));

  function automatic logic [7:0] exp_word(input logic [1:0] m, input logic [7:0] d);
    return m[0] ? d : {7'd0, d[0]};
  endfunction

  function automatic int exp_final(input int err_at);
    return (err_at == 0) ? 8 : 9;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pulse_rdy();
    stage_rdy = 1; cyc(1); stage_rdy = 0;
  endtask

  task automatic pulse_err();
    stage_err = 1; cyc(1); stage_err = 0;
  endtask

  task automatic bring_up(input logic [1:0] m, input int hold);
    int bad_hold = 0;
    int guard = 0;
    por_n = 0; ext_hold = 1; mode_pins = ~m; prog_n = 1;
    cyc(2);
    por_n = 1;
    while (init_pull && guard < 200) begin cyc(1); guard++; end
    for (int i = 0; i < hold; i++) begin
      if (stage != 4'd2) bad_hold++;
      cyc(1);
    end
    chk(bad_hold == 0 && stage == 4'd2, "R5 wait while init held", stage, 2);
    mode_pins = m; ext_hold = 0;
    cyc(1);
    chk(stage == 4'd3, "R10 sync after init rise", stage, 3);
    chk(mode_q == m, "R6 mode latched", mode_q, m);
  endtask

  task automatic cap_master(input logic [1:0] m, input logic [7:0] d, input string req);
    int guard = 0;
    cfg_din = d;
    while (cfg_clk_out && guard < 40) begin cyc(1); guard++; end
    while (!cfg_clk_out && guard < 40) begin cyc(1); guard++; end
    chk(cfg_word == exp_word(m, d), req, cfg_word, exp_word(m, d));
  endtask

  task automatic cap_slave(input logic [1:0] m, input logic [7:0] d, input string req);
    cfg_clk_in = 0; cyc(3);
    cfg_din = d; cyc(1);
    cfg_clk_in = 1; cyc(4);
    chk(cfg_word == exp_word(m, d), req, cfg_word, exp_word(m, d));
    cfg_clk_in = 0; cyc(2);
  endtask

  task automatic run_stages(input int err_at);
    pulse_rdy();
    if (err_at == 1) begin pulse_err(); return; end
    pulse_rdy();
    pulse_rdy();
    if (err_at == 2) begin pulse_err(); return; end
    pulse_rdy();
    pulse_rdy();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", stage, 8);
    finish_run();
  end

  initial begin
    int n;
    int rises;
    int gap;
    int last;
    int badc;
    void'($urandom(32'd1234));

    // reset state
    cyc(3);
    chk(stage == 4'd0 && init_pull && !done && !user_io_en, "R1 reset state", stage, 0);
    chk(!user_io_en && !done, "R12 outputs off in reset", user_io_en, 0);
    por_n = 1;
    n = 0;
    while (init_pull && n < 200) begin n++; cyc(1); end
    chk(n == CLR + 1, "R4 init low length", n, CLR + 1);
    chk(stage == 4'd2 || stage == 4'd3, "R4 released into wait", stage, 2);

    // master serial, held init
    bring_up(2'b00, 10);
    mode_pins = 2'b11; cyc(2);
    chk(mode_q == 2'b00, "R6 later mode change ignored", mode_q, 0);
    chk(cfg_clk_oe == 1'b1, "R8 clock enabled in master", cfg_clk_oe, 1);
    rises = 0; gap = 0; last = -1;
    for (int i = 0; i < 40; i++) begin
      if (cfg_clk_out && last == 0) begin rises++; if (rises == 2) gap = i; else if (rises == 1) n = i; end
      last = cfg_clk_out; cyc(1);
    end
    chk(gap - n == 2 * HALF, "R8 clock period", gap - n, 2 * HALF);
    cap_master(2'b00, 8'hA5, "R9 serial master bit");
    cap_master(2'b00, 8'h5A, "R9 serial master bit zero");

    // init pulled low after release
    ext_hold = 1;
    pulse_err();
    chk(stage == 4'd3, "R11 error ignored in sync", stage, 3);
    pulse_rdy();
    chk(stage == 4'd4, "R7 init low after release ignored", stage, 4);
    ext_hold = 0;
    pulse_rdy();
    chk(stage == 4'd5, "R10 id to load", stage, 5);
    pulse_err();
    chk(stage == 4'd5, "R11 error ignored in load", stage, 5);
    pulse_rdy();
    chk(stage == 4'd6, "R10 load to crc", stage, 6);
    pulse_rdy();
    chk(stage == 4'd7 && !done, "R10 crc to startup", stage, 7);
    pulse_rdy();
    chk(stage == 4'd8 && done && user_io_en, "R12 done in finish", stage, 8);
    chk(cfg_clk_oe == 1'b0, "R8 clock off after startup", cfg_clk_oe, 0);

    // test-port reprogram
    jtag_prog = 1; cyc(1); jtag_prog = 0;
    chk(stage == 4'd1 && init_pull && !done && !user_io_en, "R1 jtag restart", stage, 1);

    // debounce
    bring_up(2'b01, 0);
    run_stages(0);
    chk(stage == 4'd8, "R10 reached finish", stage, 8);
    prog_n = 0; cyc(PMIN - 1); prog_n = 1; cyc(3);
    chk(stage == 4'd8, "R2 short program pulse ignored", stage, 8);
    prog_n = 0; cyc(PMIN + 1);
    chk(stage == 4'd1 && init_pull, "R2 program accepted", stage, 1);

    // held program
    badc = 0;
    for (int i = 0; i < 5 * CLR; i++) begin
      if (stage != 4'd1 || !init_pull) badc++;
      cyc(1);
    end
    chk(badc == 0, "R3 held program keeps clearing", badc, 0);
    prog_n = 1;
    n = 0;
    while (init_pull && n < 200) begin n++; cyc(1); end
    chk(n <= CLR + 1, "R3 release after hold", n, CLR);

    // errors
    bring_up(2'b00, 2);
    run_stages(1);
    chk(stage == 4'd9 && init_pull, "R11 id mismatch", stage, 9);
    pulse_rdy();
    chk(stage == 4'd9 && !done, "R11 error state sticks", stage, 9);
    jtag_prog = 1; cyc(1); jtag_prog = 0;
    chk(stage == 4'd1, "R1 restart from error", stage, 1);

    // slave modes
    bring_up(2'b11, 3);
    badc = 0;
    for (int i = 0; i < 20; i++) begin
      if (cfg_clk_oe || cfg_clk_out) badc++;
      cyc(1);
    end
    chk(badc == 0, "R8 no clock in slave", badc, 0);
    cap_slave(2'b11, 8'h3C, "R9 slave parallel word");
    bring_up(2'b10, 1);
    cap_slave(2'b10, 8'hC3, "R9 slave serial bit");

    // random trials
    for (int t = 0; t < 24; t++) begin
      logic [1:0] m;
      logic [7:0] d;
      int err_at;
      m = 2'($urandom % 4);
      d = 8'($urandom);
      err_at = int'($urandom % 3);
      bring_up(m, int'($urandom % 8));
      if (m[1]) cap_slave(m, d, "R9 random capture");
      else      cap_master(m, d, "R9 random capture");
      run_stages(err_at);
      cyc(1);
      chk(stage == 4'(exp_final(err_at)), "R10 random final stage", stage, exp_final(err_at));
      chk(done == (err_at == 0), "R12 random done", done, err_at == 0);
    end

    finish_run();
  end
endmodule